// File: doc/BRIEF.md
# Per-Address Request Parker

This block sits at the request entrance of a shared GPU second-level cache controller. Each core request carries a kind (read block, victim write, victim write-back or atomic) and a line address. A small line tracker holds at most one outstanding transaction per line, and each such line is in a transient state. A request that meets a state forbidding it is not retried every cycle. It is parked in a wait queue under its line address and stays there, silent, until a completion for that address arrives. A request that may proceed is issued downstream in the same cycle it is taken.

Each tracker slot is a four-state machine. **Idle** moves to **Fill** on a read, to **Atomic-pending** on an atomic, and to **Write-in-progress** on a victim write or victim write-back. Every busy state returns to **Idle** on a completion for its address. For each candidate request, the admission decision is one of four:
- **Alloc**: the line is untracked, so the request is issued and a slot is claimed.
- **Merge**: a read meets a line in Fill and is issued with no new slot.
- **Park**: the line state forbids the request.
- **Hold**: a replay needs a slot but every slot is busy.

A completion frees its line and marks all requests parked on that address as eligible. Eligible requests are replayed one per cycle, oldest first, ahead of new traffic. Each replay passes the admission check again against the current line state.

Top module: `req_parker`

## Requirements
- R1: After reset, and after any later reset, `in_ready` is 1 and `iss_valid` is 0. The tracker and the wait queue are empty, so no parked request survives a reset.
- R2: A request to an untracked line is issued in the cycle it is accepted (`iss_valid`=1 with the same kind and address). It claims a slot: a read enters Fill, an atomic enters Atomic-pending, and a victim write or victim write-back enters Write-in-progress. Kind codes are 0 read, 1 victim write, 2 victim write-back, 3 atomic.
- R3: For a line in Write-in-progress, a request of any of the four kinds is parked, not issued.
- R4: For a line in Atomic-pending, a request of any kind is parked, including a second atomic. At most one atomic per line is ever issued before its completion.
- R5: For a line in Fill, a read is issued without claiming a slot. A victim write, victim write-back or atomic is parked.
- R6: A completion (`cpl_valid` with `cpl_addr`) returns that line to Idle and makes every request parked on that address eligible. From the next cycle on, eligible requests replay one per cycle, oldest first.
- R7: A parked request is never issued and never re-examined until a completion for its address arrives.
- R8: While any parked request is eligible, `in_ready` is 0 and no new request is taken.
- R9: A replayed request that meets a blocking state is parked again in place. All later requests for the same address lose their eligibility with it, so arrival order per address is kept and no request is lost or duplicated.
- R10: `in_ready` is 0 while the wait queue holds `DEPTH` requests or every tracker slot is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New request present |
| in_kind | input | 2 | Request kind: 0 read, 1 victim write, 2 victim write-back, 3 atomic |
| in_addr | input | AW | Line address of the new request |
| in_ready | output | 1 | New request can be taken this cycle |
| iss_valid | output | 1 | A request is issued downstream this cycle |
| iss_kind | output | 2 | Kind of the issued request |
| iss_addr | output | AW | Line address of the issued request |
| cpl_valid | input | 1 | Transaction completion for a tracked line |
| cpl_addr | input | AW | Line address of the completion |

## Verification
A slot left in the wrong state shows at the ports in the very next request to that line. That request is either issued when it should be parked, or parked with `iss_valid` low when it should be issued. A lost wakeup leaves `in_ready` high and nothing replays, which is seen one cycle after the completion. A queue that loses, duplicates or reorders entries shows in the kind and address of the replay burst that follows a completion. Backpressure faults show as `in_ready` staying high once the eighth request is parked, or once the last slot is claimed.

// File: rtl/parker_pkg.sv
package parker_pkg;

    typedef enum logic [1:0] {
        RQ_READ = 2'd0,
        RQ_VWR  = 2'd1,
        RQ_VWB  = 2'd2,
        RQ_ATOM = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_FILL = 2'd1,
        LN_ATOM = 2'd2,
        LN_WRIP = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        DC_NONE  = 3'd0,
        DC_ALLOC = 3'd1,
        DC_MERGE = 3'd2,
        DC_PARK  = 3'd3,
        DC_HOLD  = 3'd4
    } decide_t;

    // transient state a newly tracked line enters, by request kind
    function automatic line_st_t alloc_state(req_kind_t k);
        unique case (k)
            RQ_READ: return LN_FILL;
            RQ_ATOM: return LN_ATOM;
            RQ_VWR,
            RQ_VWB:  return LN_WRIP;
        endcase
    endfunction

endpackage

// File: rtl/line_tracker.sv
module line_tracker
    import parker_pkg::*;
#(
    parameter int AW  = 8,
    parameter int TRK = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output line_st_t      lk_state,
    output logic          full,
    input  logic          alloc_en,
    input  line_st_t      alloc_st,
    input  logic          free_en,
    input  logic [AW-1:0] free_addr
);
    localparam int TW = (TRK > 1) ? $clog2(TRK) : 1;

    line_st_t      slot_st [TRK];
    logic [AW-1:0] slot_ad [TRK];
    logic [TW-1:0] alloc_idx;

    // lookup and first-free slot selection
    always_comb begin
        lk_state  = LN_IDLE;
        full      = 1'b1;
        alloc_idx = '0;
        for (int i = TRK - 1; i >= 0; i--) begin
            if (slot_st[i] == LN_IDLE) begin
                full      = 1'b0;
                alloc_idx = TW'(i);
            end
        end
        for (int i = 0; i < TRK; i++) begin
            if (slot_st[i] != LN_IDLE && slot_ad[i] == lk_addr) begin
                lk_state = slot_st[i];
            end
        end
    end

    for (genvar g = 0; g < TRK; g++) begin : g_slot
        line_st_t      st_q, st_d;
        logic [AW-1:0] ad_q, ad_d;
        logic          sel;

        assign sel = alloc_en && (alloc_idx == TW'(g));

        always_comb begin
            st_d = st_q;
            ad_d = ad_q;
            unique case (st_q)
                LN_IDLE: begin
                    if (sel) begin
                        st_d = alloc_st;
                        ad_d = lk_addr;
                    end
                end
                LN_FILL, LN_ATOM, LN_WRIP: begin
                    if (free_en && ad_q == free_addr) begin
                        st_d = LN_IDLE;
                    end
                end
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= LN_IDLE;
                ad_q <= '0;
            end else begin
                st_q <= st_d;
                ad_q <= ad_d;
            end
        end

        assign slot_st[g] = st_q;
        assign slot_ad[g] = ad_q;
    end

endmodule

// File: rtl/wait_queue.sv
module wait_queue
    import parker_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  req_kind_t     push_kind,
    input  logic [AW-1:0] push_addr,
    input  logic          wake_en,
    input  logic [AW-1:0] wake_addr,
    input  logic          pop_en,
    input  logic          block_en,
    output req_kind_t     head_kind,
    output logic [AW-1:0] head_addr,
    output logic          any_elig,
    output logic          wake_hit,
    output logic [CW-1:0] count,
    output logic          full
);
    typedef struct packed {
        logic          vld;
        logic          elg;
        req_kind_t     kind;
        logic [AW-1:0] addr;
    } ent_t;

    // entries stay packed from index 0 (oldest) upward
    ent_t          ents     [DEPTH];
    ent_t          ents_d   [DEPTH];
    ent_t          ext      [DEPTH+1];
    logic [IW-1:0] head_idx;
    logic [CW-1:0] count_q;

    always_comb begin
        any_elig = 1'b0;
        head_idx = '0;
        wake_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!any_elig && ents[i].vld && ents[i].elg) begin
                any_elig = 1'b1;
                head_idx = IW'(i);
            end
            if (wake_en && ents[i].vld && ents[i].addr == wake_addr) begin
                wake_hit = 1'b1;
            end
        end
    end

    assign head_kind = ents[head_idx].kind;
    assign head_addr = ents[head_idx].addr;
    assign count     = count_q;
    assign full      = (count_q == CW'(DEPTH));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ext[i] = ents[i];
        end
        ext[DEPTH] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pop_en && IW'(i) >= head_idx) begin
                ents_d[i] = ext[i+1];
            end else begin
                ents_d[i] = ext[i];
            end
            if (push_en && count_q == CW'(i)) begin
                ents_d[i] = '{vld: 1'b1, elg: 1'b0, kind: push_kind, addr: push_addr};
            end
            if (block_en && ents_d[i].vld && ents_d[i].addr == head_addr) begin
                ents_d[i].elg = 1'b0;
            end
            if (wake_en && ents_d[i].vld && ents_d[i].addr == wake_addr) begin
                ents_d[i].elg = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
        end else begin
            count_q <= count_q + CW'(push_en) - CW'(pop_en);
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= ents_d[i];
            end
        end
    end

endmodule

// File: rtl/req_parker.sv
module req_parker
    import parker_pkg::*;
#(
    parameter int AW    = 8,
    parameter int TRK   = 4,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_kind,
    input  logic [AW-1:0] in_addr,
    output logic          in_ready,
    output logic          iss_valid,
    output logic [1:0]    iss_kind,
    output logic [AW-1:0] iss_addr,
    input  logic          cpl_valid,
    input  logic [AW-1:0] cpl_addr
);
    line_st_t      line_st;
    logic          trk_full;
    logic          alloc_en;
    req_kind_t     q_head_kind;
    logic [AW-1:0] q_head_addr;
    logic          q_any_elig;
    logic          q_wake_hit;
    logic [CW-1:0] q_count;
    logic          q_full;
    logic          push_en, pop_en, block_en;
    logic          take_new, cand_v;
    req_kind_t     cand_kind;
    logic [AW-1:0] cand_addr;
    decide_t       dec;

    // replays have priority over new traffic
    assign in_ready  = !q_any_elig && !q_full && !trk_full;
    assign take_new  = in_valid && in_ready;
    assign cand_v    = q_any_elig || take_new;
    assign cand_kind = q_any_elig ? q_head_kind : req_kind_t'(in_kind);
    assign cand_addr = q_any_elig ? q_head_addr : in_addr;

    // admission decision against the current line state
    always_comb begin
        dec = DC_NONE;
        if (cand_v) begin
            unique case (line_st)
                LN_IDLE:          dec = trk_full ? DC_HOLD : DC_ALLOC;
                LN_FILL:          dec = (cand_kind == RQ_READ) ? DC_MERGE : DC_PARK;
                LN_ATOM, LN_WRIP: dec = DC_PARK;
            endcase
        end
    end

    // outputs and sub-block controls
    always_comb begin
        iss_valid = (dec == DC_ALLOC) || (dec == DC_MERGE);
        iss_kind  = cand_kind;
        iss_addr  = cand_addr;
        alloc_en  = (dec == DC_ALLOC);
        push_en   = !q_any_elig && (dec == DC_PARK);
        block_en  = q_any_elig && (dec == DC_PARK);
        pop_en    = q_any_elig && iss_valid;
    end

    line_tracker #(.AW(AW), .TRK(TRK)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (cand_addr),
        .lk_state  (line_st),
        .full      (trk_full),
        .alloc_en  (alloc_en),
        .alloc_st  (alloc_state(cand_kind)),
        .free_en   (cpl_valid),
        .free_addr (cpl_addr)
    );

    wait_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_kind (cand_kind),
        .push_addr (cand_addr),
        .wake_en   (cpl_valid),
        .wake_addr (cpl_addr),
        .pop_en    (pop_en),
        .block_en  (block_en),
        .head_kind (q_head_kind),
        .head_addr (q_head_addr),
        .any_elig  (q_any_elig),
        .wake_hit  (q_wake_hit),
        .count     (q_count),
        .full      (q_full)
    );

endmodule

// File: rtl/parker_chk.sv
module parker_chk
    import parker_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          iss_valid,
    input logic [1:0]    iss_kind,
    input logic          cpl_valid,
    input line_st_t      line_st,
    input logic [CW-1:0] q_count,
    input logic          q_any_elig,
    input logic          q_wake_hit
);
    AST_QUEUE_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH)) |-> !in_ready); // R10

    AST_NO_ISSUE_WRIP: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (line_st != LN_WRIP)); // R3

    AST_NO_ISSUE_ATOM: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (line_st != LN_ATOM)); // R4

    AST_FILL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && line_st == LN_FILL) |-> (iss_kind == 2'd0)); // R5

    AST_WAKE_MAKES_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && q_wake_hit) |=> q_any_elig); // R6

    AST_ELIG_NEEDS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_any_elig) |-> $past(cpl_valid)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == $past(q_count)) || (q_count == $past(q_count) + 1'b1)
        || ($past(q_count) == q_count + 1'b1)); // R9

endmodule

bind req_parker parker_chk #(.AW(AW), .DEPTH(DEPTH)) u_parker_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .iss_valid  (iss_valid),
    .iss_kind   (iss_kind),
    .cpl_valid  (cpl_valid),
    .line_st    (line_st),
    .q_count    (q_count),
    .q_any_elig (q_any_elig),
    .q_wake_hit (q_wake_hit)
);

// File: tb/test_req_parker.sv
module test_req_parker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_kind = 2'd0;
    logic [7:0] in_addr = 8'd0;
    logic       in_ready;
    logic       iss_valid;
    logic [1:0] iss_kind;
    logic [7:0] iss_addr;
    logic       cpl_valid = 1'b0;
    logic [7:0] cpl_addr = 8'd0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    req_parker #(.AW(8), .TRK(4), .DEPTH(8)) i_req_parker (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr), .in_ready(in_ready),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_addr(iss_addr),
        .cpl_valid(cpl_valid), .cpl_addr(cpl_addr)
    );

    // kinds: 0 read, 1 victim write, 2 victim write-back, 3 atomic
    function automatic logic [35:0] mk(int iv, int k, int a, int cv, int ca,
                                       int er, int ei, int ek, int ea, int tag);
        return {iv[0], k[1:0], a[7:0], cv[0], ca[7:0], er[0], ei[0], ek[1:0], ea[7:0], tag[3:0]};
    endfunction

    localparam int NV = 26;
    localparam logic [35:0] VEC [0:NV-1] = '{
        mk(1,3,8'h10,0,0,     1,1,3,8'h10, 2), // R2 atomic claims A
        mk(1,0,8'h10,0,0,     1,0,0,0,     4), // R4 read parks on atomic
        mk(1,3,8'h10,0,0,     1,0,0,0,     4), // R4 second atomic parks
        mk(1,1,8'h10,0,0,     1,0,0,0,     4), // R4 victim write parks
        mk(1,0,8'h20,0,0,     1,1,0,8'h20, 2), // R2 read claims B (fill)
        mk(1,0,8'h20,0,0,     1,1,0,8'h20, 5), // R5 read merges on fill
        mk(1,2,8'h20,0,0,     1,0,0,0,     5), // R5 write-back parks
        mk(1,3,8'h20,0,0,     1,0,0,0,     5), // R5 atomic parks
        mk(0,0,0,1,8'h10,     1,0,0,0,     6), // R6 complete A
        mk(0,0,0,0,0,         0,1,0,8'h10, 6), // R6 oldest A replays
        mk(0,0,0,0,0,         0,0,0,0,     9), // R9 atomic re-parks on fill
        mk(1,1,8'h30,0,0,     1,1,1,8'h30, 2), // R2 victim write claims C
        mk(1,0,8'h30,0,0,     1,0,0,0,     3), // R3 read parks on write
        mk(0,0,0,1,8'h10,     1,0,0,0,     6), // R6 complete A fill
        mk(0,0,0,0,0,         0,1,3,8'h10, 9), // R9 atomic before victim write
        mk(0,0,0,0,0,         0,0,0,0,     9), // R9 victim write re-parks
        mk(0,0,0,1,8'h20,     1,0,0,0,     6), // R6 complete B
        mk(0,0,0,0,0,         0,1,2,8'h20, 6), // R6 write-back first
        mk(0,0,0,0,0,         0,0,0,0,     9), // R9 atomic B re-parks
        mk(0,0,0,1,8'h30,     1,0,0,0,     6), // R6 complete C
        mk(0,0,0,0,0,         0,1,0,8'h30, 6), // R6 read C replays
        mk(0,0,0,1,8'h10,     1,0,0,0,     6), // R6 complete A atomic
        mk(0,0,0,0,0,         0,1,1,8'h10, 9), // R9 victim write A last
        mk(0,0,0,1,8'h20,     1,0,0,0,     6), // R6 complete B write
        mk(0,0,0,0,0,         0,1,3,8'h20, 4), // R4 atomic B finally issues
        mk(0,0,0,0,0,         1,0,0,0,     8)  // R8 queue drained
    };

    task automatic step(input logic iv, input logic [1:0] k, input logic [7:0] a,
                        input logic cv, input logic [7:0] ca,
                        input logic er, input logic ei, input logic [1:0] ek,
                        input logic [7:0] ea, input string req);
        logic [11:0] act, exp;
        @(negedge clk);
        in_valid  = iv;
        in_kind   = k;
        in_addr   = a;
        cpl_valid = cv;
        cpl_addr  = ca;
        #1;
        act = {in_ready, iss_valid, iss_valid ? iss_kind : 2'd0, iss_valid ? iss_addr : 8'd0};
        exp = {er, ei, ei ? ek : 2'd0, ei ? ea : 8'd0};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ready/iss/kind/addr actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_chk(input logic er, input string req);
        step(0, 0, 0, 0, 0, er, 0, 0, 0, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_chk(1, "R1"); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][35], VEC[i][34:33], VEC[i][32:25], VEC[i][24], VEC[i][23:16],
                 VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11:4],
                 $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // trackers now: A write, B atomic, C fill; claim the last slot
        step(1, 3, 8'h40, 0, 0, 1, 1, 3, 8'h40, "R2");
        idle_chk(0, "R10");                              // R10 tracker full
        step(0, 0, 0, 1, 8'h40, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 8'h20, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 8'h30, 1, 0, 0, 0, "R6");

        // fill the queue with reads parked on A (write in progress)
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 8'h10, 0, 0, 1, 0, 0, 0, "R3");
        end
        step(1, 0, 8'h50, 0, 0, 0, 0, 0, 0, "R10");     // R10 queue full, not taken
        for (int i = 0; i < 20; i++) begin
            idle_chk(0, "R7");                           // R7 parked stay silent
        end
        step(0, 0, 0, 1, 8'h10, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 0, 0, 0, 1, 0, 8'h10, "R8");  // R8 replays block new traffic
        end
        idle_chk(1, "R9");                               // R9 exactly eight replays
        step(1, 0, 8'h50, 0, 0, 1, 1, 0, 8'h50, "R2");

        // reset drops parked requests and tracked lines
        step(1, 1, 8'h10, 0, 0, 1, 0, 0, 0, "R5");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_chk(1, "R1");
        step(0, 0, 0, 1, 8'h10, 1, 0, 0, 0, "R1");
        idle_chk(1, "R1");                               // R1 no replay after reset
        step(1, 1, 8'h10, 0, 0, 1, 1, 1, 8'h10, "R1");
        idle_chk(1, "R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule